// File: doc/BRIEF.md
# MIDI Serial Transmitter with Hardware Realtime Injection

This block serialises MIDI bytes onto a single asynchronous output line at 31250 baud. Ordinary traffic comes from a host-side byte queue of 16 entries that firmware fills one byte per write strobe. Alongside that path, three single-cycle event inputs from the tempo generator (24-per-quarter-note tick, transport start, transport stop) make the block insert the matching realtime byte (0xF8, 0xFA, 0xFC) into the stream on its own, so no software latency is ever added to timing-critical bytes.

A three-bit enable register chooses which of the three event kinds are turned into bytes. An event that arrives while its kind is enabled leaves a pending flag behind. At the next moment the line is free to start a byte, pending flags win over queued host bytes. A frame that is already on the wire always finishes first. The host sees a busy flag, the number of free queue slots and a sticky flag that records a write lost to a full queue.

Top module: `midi_rt_tx`

## Requirements
- R1: After reset the enable register reads 3'b111, the line is high, busy is 0, the free count equals the queue depth (16) and the overflow flag is 0.
- R2: Each byte goes out as one low start bit, eight data bits least significant first and one high stop bit, each bit lasting CLK_HZ/BAUD clock cycles (BAUD defaults to 31250). The line stays high between frames.
- R3: The free count equals the queue depth minus the bytes still queued and reads 0 when the queue is full. A host write while full is discarded and sets a sticky overflow flag that only a clear strobe resets.
- R4: Enable bit 0 turns each tick pulse into 0xF8, bit 1 turns each start pulse into 0xFA, bit 2 turns each stop pulse into 0xFC. A pulse whose bit is 0 sends nothing. A control write replaces all three bits.
- R5: When an injected byte and a host byte are both waiting at a byte boundary, the injected byte is sent first.
- R6: When several injected kinds are pending together they go out in the order 0xFC, then 0xFA, then 0xF8.
- R7: A frame that has started is completed unchanged, whatever events or writes occur during it.
- R8: The busy output is 1 from the cycle after a byte is taken from the queue or pending flags until its stop bit ends.
- R9: Several pulses of one kind that arrive before that kind is sent produce a single byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Strobe that pushes host_data into the queue |
| host_data | input | 8 | Byte to queue |
| ctrl_wr | input | 1 | Strobe that loads ctrl_data into the enable register |
| ctrl_data | input | 3 | New enables: bit 0 tick, bit 1 start, bit 2 stop |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| tick_pulse | input | 1 | 24-per-quarter-note tick event |
| start_pulse | input | 1 | Transport start event |
| stop_pulse | input | 1 | Transport stop event |
| enables | output | 3 | Current enable register |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | A frame is being shifted out |
| free_slots | output | 5 | Free queue entries |
| overflow | output | 1 | Sticky flag: a host write was lost |

## Verification
A wrong pending flag shows on the line at the next byte boundary as a missing, doubled or misordered realtime byte, so it surfaces one frame (ten bit times) after the event at most. A wrong queue pointer or count shows at once on the free count and, a frame later, as a wrong or repeated host byte in the decoded stream. A wrong bit counter or baud counter corrupts the very frame in progress, which the bench's line decoder sees as a bad stop bit or wrong data.

// File: rtl/midi_tx_pkg.sv
package midi_tx_pkg;
  localparam logic [7:0] RT_TICK  = 8'hF8;
  localparam logic [7:0] RT_START = 8'hFA;
  localparam logic [7:0] RT_STOP  = 8'hFC;
  localparam int unsigned NUM_RT  = 3;
  localparam int unsigned IDX_TICK  = 0;
  localparam int unsigned IDX_START = 1;
  localparam int unsigned IDX_STOP  = 2;

  function automatic logic [7:0] rt_code(input logic [NUM_RT-1:0] grant);
    logic [7:0] code;
    code = 8'h00;
    if (grant[IDX_STOP])       code = RT_STOP;
    else if (grant[IDX_START]) code = RT_START;
    else if (grant[IDX_TICK])  code = RT_TICK;
    return code;
  endfunction
endpackage

// File: rtl/midi_tx_fifo.sv
module midi_tx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             ovf_clr,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic [CW-1:0]    free_cnt,
  output logic             ovf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    used;
  logic             full, do_push, do_pop;

  assign full    = (used == CW'(DEPTH));
  assign empty   = (used == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      used     <= '0;
      free_cnt <= CW'(DEPTH);
      ovf      <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      used     <= used + CW'(do_push) - CW'(do_pop);
      free_cnt <= free_cnt - CW'(do_push) + CW'(do_pop);
      if (push && !do_push) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    used <= CW'(DEPTH));
  assert_drop_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> ovf);
  assert_free_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    free_cnt == CW'(DEPTH) - used);
endmodule

// File: rtl/midi_rt_arbiter.sv
module midi_rt_arbiter
  import midi_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_RT-1:0] events,
  input  logic [NUM_RT-1:0] enable,
  input  logic              take,
  output logic              any_pending,
  output logic [7:0]        code
);
  logic [NUM_RT-1:0] pend, grant;

  always_comb begin
    grant = '0;
    for (int i = NUM_RT - 1; i >= 0; i--) begin
      if (pend[i] && grant == '0) grant[i] = 1'b1;
    end
  end

  assign any_pending = |pend;
  assign code        = rt_code(grant);

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~(take ? grant : '0)) | (events & enable);
  end

  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_stop_first_R6: assert property (@(posedge clk) disable iff (rst)
    pend[IDX_STOP] |-> (code == RT_STOP));
  assert_disabled_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!take && pend == '0 && (events & enable) == '0) |=> pend == '0);
endmodule

// File: rtl/midi_uart_shift.sv
module midi_uart_shift #(
  parameter int unsigned CPB = 3200,
  localparam int unsigned BW = (CPB > 1) ? $clog2(CPB) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] data,
  output logic       busy,
  output logic       line
);
  logic [BW-1:0] baud_cnt;
  logic [3:0]    bit_idx;
  logic [9:0]    shreg;
  logic          bit_end;

  assign bit_end = (baud_cnt == BW'(CPB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      line     <= 1'b1;
      baud_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '1;
    end else if (load && !busy) begin
      busy     <= 1'b1;
      line     <= 1'b0;
      baud_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= {1'b1, data, 1'b0};
    end else if (busy) begin
      if (bit_end) begin
        baud_cnt <= '0;
        if (bit_idx == 4'd9) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          line    <= shreg[1];
          shreg   <= {1'b1, shreg[9:1]};
        end
      end else begin
        baud_cnt <= baud_cnt + 1'b1;
      end
    end
  end

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line);
  assert_bit_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_end) |=> $stable(line));
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !line);
endmodule

// File: rtl/midi_rt_tx.sv
module midi_rt_tx
  import midi_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned BAUD       = 31250,
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CPB    = CLK_HZ / BAUD,
  localparam int unsigned FREE_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [7:0]        host_data,
  input  logic              ctrl_wr,
  input  logic [NUM_RT-1:0] ctrl_data,
  input  logic              ovf_clr,
  input  logic              tick_pulse,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  output logic [NUM_RT-1:0] enables,
  output logic              tx_line,
  output logic              tx_busy,
  output logic [FREE_W-1:0] free_slots,
  output logic              overflow
);
  logic [7:0]        q_head, rt_byte, next_byte;
  logic              q_empty, rt_pending, load, q_pop, rt_take;
  logic [NUM_RT-1:0] events;

  always_ff @(posedge clk) begin
    if (rst)          enables <= '1;
    else if (ctrl_wr) enables <= ctrl_data;
  end

  assign events    = {stop_pulse, start_pulse, tick_pulse};
  assign load      = !tx_busy && (rt_pending || !q_empty);
  assign rt_take   = load && rt_pending;
  assign q_pop     = load && !rt_pending;
  assign next_byte = rt_pending ? rt_byte : q_head;

  midi_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst(rst), .push(host_wr), .push_data(host_data),
    .pop(q_pop), .ovf_clr(ovf_clr), .head(q_head), .empty(q_empty),
    .free_cnt(free_slots), .ovf(overflow));

  midi_rt_arbiter u_arb (
    .clk(clk), .rst(rst), .events(events), .enable(enables),
    .take(rt_take), .any_pending(rt_pending), .code(rt_byte));

  midi_uart_shift #(.CPB(CPB)) u_shift (
    .clk(clk), .rst(rst), .load(load), .data(next_byte),
    .busy(tx_busy), .line(tx_line));

  assert_reset_enables_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enables == 3'b111));
  assert_rt_before_fifo_R5: assert property (@(posedge clk) disable iff (rst)
    (rt_pending && !tx_busy) |-> !q_pop);
  assert_busy_after_load_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> tx_busy);
endmodule

// File: tb/sim_midi_rt_tx.sv
module sim_midi_rt_tx;
  localparam int CLK_HZ = 500_000;
  localparam int BAUD   = 31250;
  localparam int CPB    = CLK_HZ / BAUD;
  localparam int FRAME  = 10 * CPB;

  logic clk = 1'b0, rst = 1'b1;
  logic host_wr = 0, ctrl_wr = 0, ovf_clr = 0;
  logic tick_pulse = 0, start_pulse = 0, stop_pulse = 0;
  logic [7:0] host_data = 0;
  logic [2:0] ctrl_data = 0, enables;
  logic tx_line, tx_busy, overflow;
  logic [4:0] free_slots;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] rx_q [0:63];
  int rx_n = 0;

  always #5 clk = ~clk;

  midi_rt_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(16)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data),
    .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data), .ovf_clr(ovf_clr),
    .tick_pulse(tick_pulse), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .enables(enables), .tx_line(tx_line), .tx_busy(tx_busy),
    .free_slots(free_slots), .overflow(overflow));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Line decoder for R2: samples each bit at its centre.
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (!rst && tx_line === 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = tx_line;
        end
        repeat (CPB) @(negedge clk);
        check("R2 stop bit", int'(tx_line), 1);
        if (rx_n < 64) rx_q[rx_n] = b;
        rx_n++;
      end
    end
  end

  task automatic write_ctrl(input logic [2:0] v);
    ctrl_data = v; ctrl_wr = 1; @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic push(input logic [7:0] v);
    host_data = v; host_wr = 1; @(negedge clk); host_wr = 0;
  endtask

  task automatic pulse(input logic [2:0] m);
    {stop_pulse, start_pulse, tick_pulse} = m; @(negedge clk);
    {stop_pulse, start_pulse, tick_pulse} = 3'b000;
  endtask

  task automatic expect_bytes(input string req, input int base, input int n,
                              input logic [23:0] exp);
    check({req, " count"}, rx_n - base, n);
    for (int i = 0; i < n && i < 3; i++)
      check({req, " byte"}, int'(rx_q[base + i]), int'(exp[23 - 8*i -: 8]));
  endtask

  // enables, pulses(stop,start,tick), count, bytes in send order
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {3'b111, 3'b001, 2'd1, 24'hF8_00_00},   // R4 tick
    {3'b111, 3'b111, 2'd3, 24'hFC_FA_F8},   // R6 order
    {3'b000, 3'b111, 2'd0, 24'h00_00_00},   // R4 all off
    {3'b101, 3'b111, 2'd2, 24'hFC_F8_00},   // R4 start masked
    {3'b010, 3'b011, 2'd1, 24'hFA_00_00},   // R4 start only
    {3'b110, 3'b110, 2'd2, 24'hFC_FA_00}    // R6 stop before start
  };

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 enables", int'(enables), 3'b111);
    check("R1 line", int'(tx_line), 1);
    check("R1 busy", int'(tx_busy), 0);
    check("R1 free", int'(free_slots), 16);
    check("R1 overflow", int'(overflow), 0);

    for (int v = 0; v < NV; v++) begin
      base = rx_n;
      write_ctrl(VEC[v][31:29]);
      pulse(VEC[v][28:26]);
      repeat (4 * FRAME) @(negedge clk);
      expect_bytes("R4/R6 vector", base, int'(VEC[v][25:24]), VEC[v][23:0]);
    end

    // R8 busy timing and R3 free count on a single host byte
    write_ctrl(3'b111);
    base = rx_n;
    push(8'h5A);
    check("R3 free after write", int'(free_slots), 15);
    check("R8 busy not yet", int'(tx_busy), 0);
    @(negedge clk);
    check("R8 busy after take", int'(tx_busy), 1);
    check("R3 free after take", int'(free_slots), 16);
    repeat (FRAME - 2) @(negedge clk);
    check("R8 busy in stop bit", int'(tx_busy), 1);
    repeat (3) @(negedge clk);
    check("R8 busy cleared", int'(tx_busy), 0);
    repeat (CPB) @(negedge clk);
    expect_bytes("R2 host byte", base, 1, 24'h5A_00_00);

    // R5 R6 R7: events during a host frame wait for its end, then beat the queue
    base = rx_n;
    push(8'h11);
    repeat (3) @(negedge clk);
    host_data = 8'h22; host_wr = 1;
    {stop_pulse, start_pulse, tick_pulse} = 3'b111;
    @(negedge clk);
    {stop_pulse, start_pulse, tick_pulse} = 3'b000;
    push(8'h33);
    repeat (7 * FRAME) @(negedge clk);
    check("R7 count", rx_n - base, 6);
    check("R7 first byte intact", int'(rx_q[base]), 8'h11);
    expect_bytes("R5/R6 injected", base + 1, rx_n - base - 1, 24'hFC_FA_F8);
    check("R5 queue after", int'(rx_q[base + 4]), 8'h22);
    check("R5 queue after", int'(rx_q[base + 5]), 8'h33);

    // R9: two ticks during one frame merge into one 0xF8
    base = rx_n;
    push(8'h44);
    repeat (3) @(negedge clk);
    pulse(3'b001);
    repeat (20) @(negedge clk);
    pulse(3'b001);
    repeat (4 * FRAME) @(negedge clk);
    expect_bytes("R9 merge", base, 2, 24'h44_F8_00);

    // R3: 18 back-to-back writes, first is taken, 16 fill, last dropped
    base = rx_n;
    for (int i = 0; i < 18; i++) push(8'(8'h80 + i));
    check("R3 free when full", int'(free_slots), 0);
    check("R3 overflow set", int'(overflow), 1);
    repeat (18 * FRAME) @(negedge clk);
    check("R3 accepted bytes", rx_n - base, 17);
    check("R3 last kept byte", int'(rx_q[base + 16]), 8'h90);
    check("R3 overflow sticky", int'(overflow), 1);
    check("R3 free drained", int'(free_slots), 16);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    check("R3 overflow cleared", int'(overflow), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule